// File: doc/BRIEF.md
# Physical memory protection access checker

This block decides whether a single physical memory access may proceed. It receives the byte address of the access, its length in bytes, the set of permissions it needs (read, write, execute) and whether the requester runs in machine mode. It also receives the configuration byte and the address register of every protection entry. From these it returns one allow/deny bit. The entry storage sits in a neighbouring register block and reaches this checker as two flat buses.

Each entry is decoded into an inclusive byte range. Four match kinds are supported: disabled, top-of-range, naturally aligned four-byte, and naturally aligned power-of-two. The first byte and the last byte of the access are each compared against every range. A priority picker then selects the lowest-numbered enabled entry that touches the access. A verdict stage sorts the result into one of four classes. OPEN means no entry is enabled. SPLIT means the winning entry holds only one end of the access. HIT means the winning entry holds the whole access. MISS means no enabled entry is touched. Each class maps to an allow value. The verdict can be presented directly or through one output register, chosen by a parameter.

Top module: `pmp_access_check`

## Requirements
- R1: Each entry has a configuration byte whose bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 select the match kind (0 disabled, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit 7 locks the entry. Each entry also has an address register that holds a byte address shifted right by 2. Requested permissions use the same bit order: bit 0 read, bit 1 write, bit 2 execute.
- R2: A top-of-range entry i covers the bytes a with prev<<2 <= a < cur<<2. Here cur is its own register and prev is the register of entry i-1, or zero for entry 0. The entry covers nothing when cur <= prev.
- R3: A four-byte entry covers exactly the bytes cur<<2 through (cur<<2)+3.
- R4: A power-of-two entry whose register has t trailing ones covers 2^(t+3) bytes. The region starts at the register with its low t bits cleared, shifted left by 2. An all-ones register covers the whole address space.
- R5: Only enabled entries take part. The lowest-numbered enabled entry that contains the first or the last byte of the access decides the result.
- R6: If the deciding entry contains exactly one of the first and last byte, the access is denied, in every mode.
- R7: When the deciding entry contains the whole access, the granted set depends on the requester. A machine-mode requester on an unlocked entry is granted all three permissions. Any other requester, or a machine-mode requester on a locked entry, is granted only the entry's own permission bits. The access is allowed only if every requested permission is granted.
- R8: When at least one entry is enabled but none touches the access, a machine-mode access is allowed and any other access is denied.
- R9: When every entry is disabled, every access is allowed.
- R10: The last byte is address + size - 1, taken modulo the address width. A size of zero makes the last byte the final byte of the page that holds the address.
- R11: With the output register enabled, `allow` shows the verdict for the inputs present one clock edge earlier, and it reads 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | PA_W | Byte address of the first accessed byte |
| req_size | input | SIZE_W | Access length in bytes, 0 meaning up to page end |
| req_perm | input | 3 | Requested permissions: bit 0 read, bit 1 write, bit 2 execute |
| req_mmode | input | 1 | 1 when the requester runs in machine mode |
| entry_cfg | input | 8*NUM_ENTRIES | Configuration bytes, entry i in bits 8i+7:8i |
| entry_addr | input | (PA_W-2)*NUM_ENTRIES | Address registers, entry i in slice i |
| allow | output | 1 | 1 when the access may proceed |

## Verification
The bench builds the checker with four entries, a 16-bit physical address, a 6-bit size field, 256-byte pages and the output register on. This small address space lets random accesses land on entry boundaries often, so split, hit and miss verdicts all occur. It also puts the all-ones whole-space region and the address wrap of R10 within easy reach. The short page makes zero-size accesses cross four-byte and small power-of-two regions, and four entries are enough to exercise priority between overlapping regions and the top-of-range use of the previous register.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_kind_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_kind_e kind;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

    typedef enum logic [1:0] {
        VERD_OPEN  = 2'd0,
        VERD_SPLIT = 2'd1,
        VERD_HIT   = 2'd2,
        VERD_MISS  = 2'd3
    } verdict_e;

    localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/pmp_range_decode.sv
module pmp_range_decode
    import pmp_chk_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  match_kind_e       kind,
    input  logic [PA_W-3:0]   cur_reg,
    input  logic [PA_W-3:0]   prev_reg,
    output logic [PA_W-1:0]   lo,
    output logic [PA_W-1:0]   hi,
    output logic              valid
);
    localparam int RW = PA_W - 2;
    localparam logic [RW-1:0]   ONE_R  = RW'(1);
    localparam logic [PA_W-1:0] ONE_B  = PA_W'(1);
    localparam logic [PA_W-1:0] LOW2_B = PA_W'(3);

    logic [PA_W-1:0] cur_b;
    logic [PA_W-1:0] prev_b;
    logic [RW-1:0]   tail_r;
    logic [PA_W-1:0] tail_b;

    assign cur_b  = {cur_reg, 2'b00};
    assign prev_b = {prev_reg, 2'b00};
    // trailing ones plus the first zero above them; all ones for an all-ones register
    assign tail_r = cur_reg ^ (cur_reg + ONE_R);
    assign tail_b = {tail_r, 2'b11};

    always_comb begin
        unique case (kind)
            MATCH_OFF: begin
                lo    = '0;
                hi    = '0;
                valid = 1'b0;
            end
            MATCH_TOR: begin
                lo    = prev_b;
                hi    = cur_b - ONE_B;
                valid = (cur_reg > prev_reg);
            end
            MATCH_NA4: begin
                lo    = cur_b;
                hi    = cur_b | LOW2_B;
                valid = 1'b1;
            end
            MATCH_NAPOT: begin
                lo    = cur_b & ~tail_b;
                hi    = cur_b | tail_b;
                valid = 1'b1;
            end
        endcase
    end

    // R3: a four-byte region spans exactly four bytes
    p_na4_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MATCH_NA4) |-> ((hi - lo) == LOW2_B));

    // R4: a power-of-two region is aligned to its own size
    p_napot_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == MATCH_NAPOT) |-> (((lo & (hi - lo)) == '0) && (lo <= hi)));

    // R2: a non-empty top-of-range region is ordered
    p_tor_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == MATCH_TOR) && valid) |-> (lo <= hi));

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] hit,
    output logic [NUM_ENTRIES-1:0] sel,
    output logic                   any
);
    logic [NUM_ENTRIES:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chain
        assign seen[i+1] = seen[i] | hit[i];
        assign sel[i]    = hit[i] & ~seen[i];
    end

    assign any = seen[NUM_ENTRIES];

    // R5: at most one winner, and it is one of the touched entries
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && ((sel & ~hit) == '0));

    // R5: no touched entry sits below the winner
    p_sel_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((hit & (sel - 1'b1)) == '0));

    p_sel_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (sel != '0));

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int PA_W        = 32,
    parameter int SIZE_W      = 12,
    parameter int PAGE_SHIFT  = 12,
    parameter bit OUT_REG     = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PA_W-1:0]                 req_addr,
    input  logic [SIZE_W-1:0]               req_size,
    input  logic [2:0]                      req_perm,
    input  logic                            req_mmode,
    input  logic [8*NUM_ENTRIES-1:0]        entry_cfg,
    input  logic [(PA_W-2)*NUM_ENTRIES-1:0] entry_addr,
    output logic                            allow
);
    localparam int RW = PA_W - 2;
    localparam logic [PA_W-1:0] ONE_B     = PA_W'(1);
    localparam logic [PA_W-1:0] PAGE_MASK = PA_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    // ---------------- last byte of the access (R10)
    logic [PA_W-1:0] first_b;
    logic [PA_W-1:0] last_b;

    assign first_b = req_addr;
    assign last_b  = (req_size == '0) ? (req_addr | PAGE_MASK)
                                      : (req_addr + PA_W'(req_size) - ONE_B);

    // ---------------- per-entry decode and containment
    entry_cfg_t             cfg_s   [NUM_ENTRIES];
    logic [2:0]             perm_v  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] lock_v;
    logic [NUM_ENTRIES-1:0] active;
    logic [NUM_ENTRIES-1:0] part;
    logic [NUM_ENTRIES-1:0] full;
    logic [NUM_ENTRIES-1:0] hit;
    logic [NUM_ENTRIES-1:0] rsvd_unused;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        logic [RW-1:0]   cur_reg;
        logic [RW-1:0]   prev_reg;
        logic [PA_W-1:0] lo;
        logic [PA_W-1:0] hi;
        logic            valid;
        logic            in_first;
        logic            in_last;

        assign cfg_s[i]       = entry_cfg_t'(entry_cfg[8*i +: 8]);
        assign perm_v[i]      = {cfg_s[i].x, cfg_s[i].w, cfg_s[i].r};
        assign lock_v[i]      = cfg_s[i].lock;
        assign rsvd_unused[i] = ^cfg_s[i].rsvd;
        assign cur_reg        = entry_addr[RW*i +: RW];

        if (i == 0) begin : g_base
            assign prev_reg = '0;
        end else begin : g_prev
            assign prev_reg = entry_addr[RW*(i-1) +: RW];
        end

        pmp_range_decode #(
            .PA_W (PA_W)
        ) u_decode (
            .clk      (clk),
            .rst_n    (rst_n),
            .kind     (cfg_s[i].kind),
            .cur_reg  (cur_reg),
            .prev_reg (prev_reg),
            .lo       (lo),
            .hi       (hi),
            .valid    (valid)
        );

        assign in_first  = valid && (first_b >= lo) && (first_b <= hi);
        assign in_last   = valid && (last_b  >= lo) && (last_b  <= hi);
        assign active[i] = (cfg_s[i].kind != MATCH_OFF);
        assign part[i]   = active[i] & (in_first ^ in_last);
        assign full[i]   = active[i] & in_first & in_last;
        assign hit[i]    = part[i] | full[i];
    end

    // ---------------- fixed priority selection (R5)
    logic [NUM_ENTRIES-1:0] sel;
    logic                   any_hit;

    pmp_first_hit #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .sel   (sel),
        .any   (any_hit)
    );

    logic [2:0] win_perm;
    logic       win_lock;
    logic       win_part;

    always_comb begin
        win_perm = '0;
        win_lock = 1'b0;
        win_part = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (sel[i]) begin
                win_perm = win_perm | perm_v[i];
                win_lock = win_lock | lock_v[i];
                win_part = win_part | part[i];
            end
        end
    end

    // ---------------- verdict classification and allow decision
    verdict_e   verdict;
    logic [2:0] granted;
    logic       allow_d;

    always_comb begin
        if (active == '0)       verdict = VERD_OPEN;
        else if (!any_hit)      verdict = VERD_MISS;
        else if (win_part)      verdict = VERD_SPLIT;
        else                    verdict = VERD_HIT;
    end

    assign granted = (req_mmode && !win_lock) ? PERM_ALL : win_perm;

    always_comb begin
        unique case (verdict)
            VERD_OPEN:  allow_d = 1'b1;
            VERD_SPLIT: allow_d = 1'b0;
            VERD_HIT:   allow_d = ((req_perm & ~granted) == 3'b000);
            VERD_MISS:  allow_d = req_mmode;
        endcase
    end

    // ---------------- output stage (R11)
    if (OUT_REG) begin : g_oreg
        logic allow_q;
        logic armed;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                allow_q <= 1'b0;
                armed   <= 1'b0;
            end else begin
                allow_q <= allow_d;
                armed   <= 1'b1;
            end
        end

        assign allow = allow_q;

        // R11: registered output follows the previous cycle's verdict
        p_out_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (allow == $past(allow_d)));
    end else begin : g_comb
        assign allow = allow_d;
    end

    // R9: nothing enabled means everything passes
    p_no_rules_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> allow_d);

    // R6: a winner holding only one end always denies
    p_split_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel & part) != '0) |-> !allow_d);

    // R8: untouched with rules present follows the mode
    p_miss_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((active != '0) && (hit == '0)) |-> (allow_d == req_mmode));

    // R7: a non-machine requester never gets more than the winner's bits
    p_user_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((sel & full) != '0) && !req_mmode && allow_d) |-> ((req_perm & ~win_perm) == 3'b000));

endmodule

// File: tb/pmp_access_check_bench.sv
module pmp_access_check_bench;
    localparam int NE  = 4;
    localparam int PAW = 16;
    localparam int SW  = 6;
    localparam int PS  = 8;
    localparam int RWB = PAW - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PAW-1:0]    req_addr = '0;
    logic [SW-1:0]     req_size = '0;
    logic [2:0]        req_perm = '0;
    logic              req_mmode = 1'b0;
    logic [8*NE-1:0]   entry_cfg;
    logic [RWB*NE-1:0] entry_addr;
    logic              allow;

    logic [7:0]     cfg_b [NE];
    logic [RWB-1:0] areg  [NE];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            entry_cfg[8*i +: 8]    = cfg_b[i];
            entry_addr[RWB*i +: RWB] = areg[i];
        end
    end

    pmp_access_check #(
        .NUM_ENTRIES (NE),
        .PA_W        (PAW),
        .SIZE_W      (SW),
        .PAGE_SHIFT  (PS),
        .OUT_REG     (1'b1)
    ) u_pmp_access_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_perm   (req_perm),
        .req_mmode  (req_mmode),
        .entry_cfg  (entry_cfg),
        .entry_addr (entry_addr),
        .allow      (allow)
    );

    function automatic logic [7:0] mk(input bit lk, input int kind, input logic [2:0] p);
        return {lk, 2'b00, 2'(kind), p};
    endfunction

    task automatic clear_all();
        for (int i = 0; i < NE; i++) begin
            cfg_b[i] = 8'h00;
            areg[i]  = '0;
        end
    endtask

    // containment of a byte in entry i, computed from R2, R3, R4
    function automatic bit inside_ent(input int i, input longint x);
        longint lo;
        longint sz;
        int     t;
        case (cfg_b[i][4:3])
            2'd1: begin
                lo = (i == 0) ? 0 : longint'(areg[i-1]) * 4;
                return (x >= lo) && (x < longint'(areg[i]) * 4);
            end
            2'd2: begin
                lo = longint'(areg[i]) * 4;
                return (x >= lo) && (x < lo + 4);
            end
            2'd3: begin
                t = 0;
                while (t < RWB && areg[i][t]) t++;
                if (t == RWB) begin
                    lo = 0;
                    sz = longint'(1) << PAW;
                end else begin
                    sz = longint'(1) << (t + 3);
                    lo = ((longint'(areg[i]) >> t) << t) * 4;
                end
                return (x >= lo) && (x < lo + sz);
            end
            default: return 0;
        endcase
    endfunction

    function automatic logic model(input logic [PAW-1:0] a, input int sz,
                                   input logic [2:0] p, input bit mm);
        bit     anyon;
        longint last;
        bit     s;
        bit     e;
        logic [2:0] g;
        anyon = 0;
        for (int i = 0; i < NE; i++) if (cfg_b[i][4:3] != 2'd0) anyon = 1;
        if (!anyon) return 1'b1;
        if (sz == 0) last = longint'(a) | ((longint'(1) << PS) - 1);
        else         last = (longint'(a) + sz - 1) & ((longint'(1) << PAW) - 1);
        for (int i = 0; i < NE; i++) begin
            if (cfg_b[i][4:3] == 2'd0) continue;
            s = inside_ent(i, longint'(a));
            e = inside_ent(i, last);
            if (s != e) return 1'b0;
            if (s && e) begin
                g = (mm && !cfg_b[i][7]) ? 3'b111 : cfg_b[i][2:0];
                return ((p & ~g) == 3'b000);
            end
        end
        return mm;
    endfunction

    task automatic run(input string tag, input logic [PAW-1:0] a, input int sz,
                       input logic [2:0] p, input bit mm, input logic expv);
        @(negedge clk);
        req_addr  = a;
        req_size  = SW'(sz);
        req_perm  = p;
        req_mmode = mm;
        @(negedge clk);
        checks++;
        if (allow !== expv) begin
            fails++;
            $display("FAIL %s: allow=%0b expected=%0b (addr=%h size=%0d perm=%b m=%0b)",
                     tag, allow, expv, a, sz, p, mm);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        clear_all();
        repeat (3) @(negedge clk);
        checks++;
        if (allow !== 1'b0) begin
            fails++;
            $display("FAIL R11: allow=%0b expected=0 during reset", allow);
        end
        rst_n = 1'b1;

        // R9: no enabled entries
        areg[1] = 14'h0123;
        run("R9 user", 16'h1234, 4, 3'b100, 0, 1'b1);
        run("R9 machine", 16'h0000, 0, 3'b111, 1, 1'b1);

        // setup A: R1 encoding, TOR, NA4, NAPOT
        clear_all();
        areg[0] = 14'h0010;
        cfg_b[1] = mk(0, 1, 3'b001); areg[1] = 14'h0020;
        cfg_b[2] = mk(0, 2, 3'b011); areg[2] = 14'h0040;
        cfg_b[3] = mk(0, 3, 3'b100); areg[3] = 14'h0083;
        run("R2 tor low edge", 16'h0040, 4, 3'b001, 0, 1'b1);
        run("R2 tor high edge", 16'h007C, 4, 3'b001, 0, 1'b1);
        run("R2 tor above", 16'h0080, 1, 3'b001, 0, 1'b0);
        run("R2 tor below", 16'h003C, 4, 3'b001, 0, 1'b0);
        run("R7 user write", 16'h0040, 4, 3'b010, 0, 1'b0);
        run("R7 machine unlocked", 16'h0040, 4, 3'b010, 1, 1'b1);
        run("R6 machine split", 16'h007E, 4, 3'b001, 1, 1'b0);
        run("R8 machine miss", 16'h0300, 4, 3'b001, 1, 1'b1);
        run("R8 user miss", 16'h0300, 4, 3'b001, 0, 1'b0);
        run("R3 na4 write", 16'h0100, 4, 3'b010, 0, 1'b1);
        run("R3 na4 next", 16'h0104, 1, 3'b001, 0, 1'b0);
        run("R3 na4 split", 16'h0102, 4, 3'b001, 0, 1'b0);
        run("R4 napot top", 16'h021C, 4, 3'b100, 0, 1'b1);
        run("R4 napot past", 16'h0220, 4, 3'b100, 0, 1'b0);
        run("R1 perm bits", 16'h0200, 4, 3'b001, 0, 1'b0);
        cfg_b[3] = mk(1, 3, 3'b100);
        run("R7 machine locked read", 16'h0200, 4, 3'b001, 1, 1'b0);
        run("R7 machine locked exec", 16'h0200, 4, 3'b100, 1, 1'b1);

        // setup C: whole-space region wins over later entry
        clear_all();
        cfg_b[0] = mk(0, 3, 3'b001); areg[0] = 14'h3FFF;
        cfg_b[1] = mk(0, 2, 3'b111); areg[1] = 14'h0040;
        run("R5 first wins deny", 16'h0100, 4, 3'b010, 0, 1'b0);
        run("R4 whole space read", 16'hFFF0, 4, 3'b001, 0, 1'b1);
        run("R10 wrap", 16'hFFFE, 4, 3'b001, 0, 1'b1);
        run("R4 whole machine", 16'h8000, 4, 3'b010, 1, 1'b1);

        // setup E: reversed order
        clear_all();
        cfg_b[0] = mk(0, 2, 3'b111); areg[0] = 14'h0040;
        cfg_b[1] = mk(0, 3, 3'b000); areg[1] = 14'h3FFF;
        run("R5 low index allow", 16'h0100, 4, 3'b010, 0, 1'b1);

        // setup D: zero size reaches page end
        clear_all();
        cfg_b[0] = mk(0, 2, 3'b001); areg[0] = 14'h0040;
        cfg_b[1] = mk(0, 3, 3'b001); areg[1] = 14'h005F;
        run("R10 zero size split", 16'h0100, 0, 3'b001, 0, 1'b0);
        run("R10 zero size inside", 16'h0180, 0, 3'b001, 0, 1'b1);
        run("R10 long size", 16'h0180, 63, 3'b001, 0, 1'b1);

        // random mix covering R2 to R10
        for (int v = 0; v < 3000; v++) begin
            logic [PAW-1:0] a;
            int             sz;
            int             j;
            if (v % 8 == 0) begin
                for (int i = 0; i < NE; i++) begin
                    cfg_b[i] = 8'($urandom);
                    if ($urandom_range(0, 3) == 0) areg[i] = RWB'($urandom);
                    else                           areg[i] = RWB'($urandom_range(0, 255));
                end
            end
            if ($urandom_range(0, 1) == 0) begin
                a = PAW'($urandom);
            end else begin
                j = $urandom_range(0, NE - 1);
                a = PAW'(int'(areg[j]) * 4 + $urandom_range(0, 16) - 8);
            end
            sz = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 63);
            begin
                logic [2:0] p;
                bit         mm;
                p  = 3'($urandom);
                mm = 1'($urandom);
                run("R5 random", a, sz, p, mm, model(a, sz, p, mm));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule